// File: doc/BRIEF.md
# S/PDIF Biphase Transmitter

This block takes stereo audio from a three-wire serial audio link (bit clock, word select, data) and turns it into a biphase-mark-coded S/PDIF line signal. Its front end deserializes each half-frame in one of three justification formats and at one of four sample widths. It then holds the latest left/right pair until the line encoder needs it.

The encoder runs on its own half-cell enable, which the system derives from an oversampling clock at twice the line bit rate. It sends two 32-slot subframes per frame. Each subframe holds a preamble, 24 audio slots, validity, user, channel-status and parity slots. The channel-status slot comes from a fixed parameter word. The serial input and the encoder are decoupled: a pair latched from the input is used from the next frame boundary on, and it is sent again for as long as no newer pair has arrived.

Top module: `spdif_tx`

## Requirements
- R1: After reset the line output is 0. The first subframe sent after reset is a left subframe that carries the block-start preamble.
- R2: The line output changes only on a clock edge at which the half-cell enable is high. Each such edge advances the encoder by exactly one half-cell, and a subframe spans 64 half-cells.
- R3: In slots 4 to 31 the line toggles at the start of every bit cell. It toggles again at mid-cell only when the bit is 1.
- R4: The 8 half-cells of a preamble, XORed with the line level just before the subframe and read in send order, equal 11101000 for the block-start preamble, 11100010 for other left subframes and 11100100 for right subframes.
- R5: Subframes alternate left, right. The block-start preamble marks the left subframe of every BLOCK_FRAMES-th frame (default 192), counting from frame 0 after reset.
- R6: Slots 4 to 27 carry the 24-bit audio field LSB first. A sample of fewer than 24 bits sits at the MSB end (slot 27), and zeros fill the slots below it.
- R7: The width select picks the sample width: code 0 gives 16 bits, 1 gives 18, 2 gives 20 and 3 gives 24.
- R8: The format select picks how samples sit in each 32-bit half-frame. Word select low is the left half and high is the right half; bit position 0 is the first bit-clock rising edge after word select changes. Code 0 puts the MSB at position 0. Code 1 puts it at position 1. Code 2 puts the LSB at position 31. The data is MSB first in every format.
- R9: Slot 28 (validity) and slot 29 (user) are 0. Slot 30 carries bit f of CS_BITS for frame f < 32 of the block, and 0 for later frames.
- R10: Slot 31 makes the number of ones in slots 4 to 31 even.
- R11: A pair is latched when a right half-frame ends. It is used from the next frame boundary of the encoder on, and it is repeated while no newer pair arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk | input | 1 | Serial audio bit clock, sampled on clk |
| lrclk | input | 1 | Word select: low for the left half, high for the right half |
| sdata | input | 1 | Serial audio data, MSB first |
| fmt | input | 2 | Justification format code (R8) |
| wsel | input | 2 | Sample width code (R7) |
| ovs_en | input | 1 | Half-cell enable from the oversampling clock |
| spdif_out | output | 1 | Biphase-mark-coded line output |

## Verification
The bench builds the block with two synchronizer stages, a block length of 192 frames and a channel-status word with scattered ones. The input bit clock and the half-cell enable are chosen so that one input frame takes as long as one output frame. About 80 stereo pairs are sent, so the run crosses a block boundary and the block-start preamble can be seen on its second appearance. Every combination of format and width is also driven with directed all-ones and LSB-only samples, which show where the sample lands in the audio slots. The 32-entry channel-status word lets the bench see both the parameter bits and the zero tail of the block.

// File: rtl/spdif_tx_pkg.sv
package spdif_tx_pkg;

   typedef enum logic [1:0] {
      FMT_MSB_FIRST = 2'd0,
      FMT_ONE_DELAY = 2'd1,
      FMT_LSB_END   = 2'd2
   } fmt_e;

   localparam int AUDIO_BITS = 24;
   localparam int HALF_SLOTS = 32;

   localparam logic [7:0] PRE_BLOCK = 8'b11101000;
   localparam logic [7:0] PRE_LEFT  = 8'b11100010;
   localparam logic [7:0] PRE_RIGHT = 8'b11100100;

   function automatic logic [5:0] word_bits(input logic [1:0] code);
      case (code)
         2'd0:    return 6'd16;
         2'd1:    return 6'd18;
         2'd2:    return 6'd20;
         default: return 6'd24;
      endcase
   endfunction

   function automatic logic [4:0] pad_bits(input logic [1:0] code);
      case (code)
         2'd0:    return 5'd8;
         2'd1:    return 5'd6;
         2'd2:    return 5'd4;
         default: return 5'd0;
      endcase
   endfunction

endpackage

// File: rtl/sai_deser.sv
module sai_deser
   import spdif_tx_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  sclk,
   input  logic                  lrclk,
   input  logic                  sdata,
   input  logic [1:0]            fmt,
   input  logic [1:0]            wsel,
   output logic [AUDIO_BITS-1:0] pair_l,
   output logic [AUDIO_BITS-1:0] pair_r
);

   logic [2:0] pins;
   logic       sclk_d;
   logic       lr_last;
   logic [5:0] pos;
   logic [AUDIO_BITS-1:0] shreg;
   logic [AUDIO_BITS-1:0] left_hold;

   generate
      if (SYNC_STAGES == 2) begin : g_sync2
         logic [2:0] st1;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               st1  <= '0;
               pins <= '0;
            end else begin
               st1  <= {sclk, lrclk, sdata};
               pins <= st1;
            end
         end
      end else begin : g_sync1
         always_ff @(posedge clk) begin
            if (!rst_n) pins <= '0;
            else        pins <= {sclk, lrclk, sdata};
         end
      end
   endgenerate

   logic       s_clk, s_lr, s_dat, rise, edge_lr;
   logic [5:0] nxt_pos, wb;
   logic       take;
   logic [AUDIO_BITS-1:0] base;

   function automatic logic [AUDIO_BITS-1:0] align(input logic [AUDIO_BITS-1:0] v,
                                                    input logic [1:0] code);
      logic [AUDIO_BITS-1:0] mask;
      mask = ~({AUDIO_BITS{1'b1}} << word_bits(code));
      return (v & mask) << pad_bits(code);
   endfunction

   always_comb begin
      {s_clk, s_lr, s_dat} = pins;
      rise    = s_clk & ~sclk_d;
      edge_lr = s_lr ^ lr_last;
      wb      = word_bits(wsel);
      nxt_pos = edge_lr ? 6'd0 : ((pos == 6'd63) ? pos : pos + 6'd1);
      base    = edge_lr ? '0 : shreg;
      case (fmt_e'(fmt))
         FMT_ONE_DELAY: take = (nxt_pos >= 6'd1) && (nxt_pos <= wb);
         FMT_LSB_END:   take = (nxt_pos >= (6'd32 - wb)) && (nxt_pos <= 6'd31);
         default:       take = (nxt_pos < wb);
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sclk_d    <= 1'b0;
         lr_last   <= 1'b0;
         pos       <= 6'd63;
         shreg     <= '0;
         left_hold <= '0;
         pair_l    <= '0;
         pair_r    <= '0;
      end else begin
         sclk_d <= s_clk;
         if (rise) begin
            lr_last <= s_lr;
            pos     <= nxt_pos;
            shreg   <= take ? {base[AUDIO_BITS-2:0], s_dat} : base;
            if (edge_lr) begin
               if (!lr_last) begin
                  left_hold <= align(shreg, wsel);
               end else begin
                  pair_l <= left_hold;
                  pair_r <= align(shreg, wsel);
               end
            end
         end
      end
   end

endmodule

// File: rtl/bmc_encoder.sv
module bmc_encoder
   import spdif_tx_pkg::*;
#(
   parameter int          BLOCK_FRAMES = 192,
   parameter logic [31:0] CS_BITS      = 32'h0,
   parameter int          FW           = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  ovs_en,
   input  logic [AUDIO_BITS-1:0] pair_l,
   input  logic [AUDIO_BITS-1:0] pair_r,
   output logic                  line,
   output logic [5:0]            hc,
   output logic                  sub,
   output logic [FW-1:0]         frame
);

   localparam logic [FW-1:0] LAST_FRAME = FW'(BLOCK_FRAMES - 1);

   logic [AUDIO_BITS-1:0] cur_l, cur_r, smp;
   logic                  base_r, base, cbit, nxt;
   logic [26:0]           body;
   logic [31:0]           word;
   logic [7:0]            pat;

   always_comb begin
      smp  = sub ? cur_r : cur_l;
      cbit = (int'(frame) < 32) ? CS_BITS[frame[4:0]] : 1'b0;
      body = {cbit, 1'b0, 1'b0, smp};
      word = {^body, body, 4'b0000};
      if (sub)               pat = PRE_RIGHT;
      else if (frame == '0)  pat = PRE_BLOCK;
      else                   pat = PRE_LEFT;
      base = (hc == 6'd0) ? line : base_r;
      if (hc < 6'd8)   nxt = pat[3'd7 - hc[2:0]] ^ base;
      else if (!hc[0]) nxt = ~line;
      else             nxt = word[hc[5:1]] ? ~line : line;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         line   <= 1'b0;
         hc     <= '0;
         sub    <= 1'b0;
         frame  <= '0;
         base_r <= 1'b0;
         cur_l  <= '0;
         cur_r  <= '0;
      end else if (ovs_en) begin
         line <= nxt;
         hc   <= hc + 6'd1;
         if (hc == 6'd0) base_r <= line;
         if (hc == 6'd63) begin
            sub <= ~sub;
            if (sub) begin
               frame <= (frame == LAST_FRAME) ? '0 : frame + 1'b1;
               cur_l <= pair_l;
               cur_r <= pair_r;
            end
         end
      end
   end

endmodule

// File: rtl/spdif_tx.sv
module spdif_tx
   import spdif_tx_pkg::*;
#(
   parameter int          SYNC_STAGES  = 2,
   parameter int          BLOCK_FRAMES = 192,
   parameter logic [31:0] CS_BITS      = 32'h0200_0104
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sclk,
   input  logic       lrclk,
   input  logic       sdata,
   input  logic [1:0] fmt,
   input  logic [1:0] wsel,
   input  logic       ovs_en,
   output logic       spdif_out
);

   localparam int FW = $clog2(BLOCK_FRAMES);

   generate
      if (SYNC_STAGES < 1 || SYNC_STAGES > 2) begin : g_bad_sync
         $error("SYNC_STAGES must be 1 or 2");
      end
      if (BLOCK_FRAMES < 32 || BLOCK_FRAMES > 1024) begin : g_bad_block
         $error("BLOCK_FRAMES must lie in 32..1024");
      end
   endgenerate

   logic [AUDIO_BITS-1:0] pair_l, pair_r;
   logic [5:0]            hc;
   logic                  sub;
   logic [FW-1:0]         frame;

   sai_deser #(.SYNC_STAGES(SYNC_STAGES)) u_deser (
      .clk(clk), .rst_n(rst_n), .sclk(sclk), .lrclk(lrclk), .sdata(sdata),
      .fmt(fmt), .wsel(wsel), .pair_l(pair_l), .pair_r(pair_r)
   );

   bmc_encoder #(.BLOCK_FRAMES(BLOCK_FRAMES), .CS_BITS(CS_BITS), .FW(FW)) u_enc (
      .clk(clk), .rst_n(rst_n), .ovs_en(ovs_en), .pair_l(pair_l), .pair_r(pair_r),
      .line(spdif_out), .hc(hc), .sub(sub), .frame(frame)
   );

endmodule

// File: rtl/spdif_tx_chk.sv
module spdif_tx_chk #(
   parameter int BLOCK_FRAMES = 192,
   parameter int FW           = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          ovs_en,
   input logic          line,
   input logic [5:0]    hc,
   input logic          sub,
   input logic [FW-1:0] frame
);

   AST_LINE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !ovs_en |=> $stable(line)); // R2

   AST_HALF_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      ovs_en |=> (hc == $past(hc) + 6'd1)); // R2

   AST_CELL_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      (ovs_en && hc >= 6'd8 && !hc[0]) |=> (line != $past(line))); // R3

   AST_SUB_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
      (ovs_en && hc == 6'd63) |=> (sub != $past(sub))); // R5

   AST_FRAME_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      int'(frame) < BLOCK_FRAMES); // R5

endmodule

bind spdif_tx spdif_tx_chk #(.BLOCK_FRAMES(BLOCK_FRAMES), .FW(FW)) u_chk (
   .clk(clk), .rst_n(rst_n), .ovs_en(ovs_en), .line(spdif_out),
   .hc(hc), .sub(sub), .frame(frame)
);

// File: tb/spdif_tx_bench.sv
module spdif_tx_bench;

   localparam logic [31:0] CS = 32'h8421_0B05;
   localparam int          BF = 192;

   logic clk = 1'b0, rst_n = 1'b0;
   logic sclk = 1'b0, lrclk = 1'b0, sdata = 1'b0, ovs_en = 1'b0;
   logic [1:0] fmt = 2'd0, wsel = 2'd0;
   logic spdif_out;

   int total = 0, bad = 0;
   logic active = 1'b0, settled = 1'b0, done = 1'b0;
   logic [23:0] exp_l = '0, exp_r = '0;
   logic h [0:63];
   int   hi = 0, fidx = 0, sidx = 0;
   logic prior = 1'b0, last = 1'b0;

   always #2 clk = ~clk;

   spdif_tx #(.SYNC_STAGES(2), .BLOCK_FRAMES(BF), .CS_BITS(CS)) u_spdif_tx (
      .clk(clk), .rst_n(rst_n), .sclk(sclk), .lrclk(lrclk), .sdata(sdata),
      .fmt(fmt), .wsel(wsel), .ovs_en(ovs_en), .spdif_out(spdif_out)
   );

   function automatic int nbits(input logic [1:0] w);
      return (w == 2'd0) ? 16 : (w == 2'd1) ? 18 : (w == 2'd2) ? 20 : 24;
   endfunction

   function automatic logic [23:0] placed(input logic [23:0] s, input logic [1:0] w);
      int n = nbits(w);
      logic [31:0] m = (32'h1 << n) - 1;
      logic [31:0] v = ({8'h0, s} & m) << (24 - n);
      return v[23:0];
   endfunction

   function automatic logic ser_bit(input logic [23:0] s, input int k,
                                    input logic [1:0] f, input logic [1:0] w);
      int n = nbits(w);
      if (f == 2'd1) return (k >= 1 && k <= n) ? s[n-k] : 1'b0;
      if (f == 2'd2) return (k >= 32 - n) ? s[31-k] : 1'b0;
      return (k < n) ? s[n-1-k] : 1'b0;
   endfunction

   task automatic tally(input logic ok, input string req, input logic [31:0] act,
                        input logic [31:0] expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h (subframe %0d)", req, act, expv, sidx);
      end
   endtask

   task automatic send_frame(input logic [23:0] sl, input logic [23:0] sr,
                             input logic [1:0] f, input logic [1:0] w);
      for (int b = 0; b < 64; b++) begin
         @(negedge clk);
         sclk  = 1'b0;
         lrclk = (b >= 32);
         sdata = ser_bit((b < 32) ? sl : sr, b % 32, f, w);
         @(negedge clk);
         @(negedge clk);
         sclk = 1'b1;
         @(negedge clk);
      end
   endtask

   task automatic check_sub();
      logic [7:0]  pat, exp_pat;
      logic [31:0] dw;
      logic        edges_ok;
      logic        is_right;
      logic [23:0] exp_a;
      is_right = sidx[0];
      for (int i = 0; i < 8; i++) pat[7-i] = h[i] ^ prior;
      exp_pat = is_right ? 8'b11100100 : ((fidx == 0) ? 8'b11101000 : 8'b11100010);
      // R1 (first subframe after reset), R4 patterns, R5 placement
      tally(pat == exp_pat, "R4 R5 preamble", {24'h0, pat}, {24'h0, exp_pat});
      dw = '0;
      edges_ok = 1'b1;
      for (int s = 4; s < 32; s++) begin
         if (h[2*s] == h[2*s-1]) edges_ok = 1'b0;
         dw[s] = h[2*s] ^ h[2*s+1];
      end
      tally(edges_ok, "R3 cell-start toggle", {31'h0, edges_ok}, 32'h1);
      tally(^dw[31:4] == 1'b0, "R10 parity", {31'h0, ^dw[31:4]}, 32'h0);
      tally(dw[29:28] == 2'b00, "R9 validity/user", {30'h0, dw[29:28]}, 32'h0);
      tally(dw[30] == ((fidx < 32) ? CS[fidx] : 1'b0), "R9 channel status",
            {31'h0, dw[30]}, {31'h0, (fidx < 32) ? CS[fidx] : 1'b0});
      if (settled) begin
         // R11: pair held across repeated frames
         exp_a = is_right ? exp_r : exp_l;
         tally(dw[27:4] == exp_a, "R6 R7 R8 R11 audio", {8'h0, dw[27:4]}, {8'h0, exp_a});
      end
      if (is_right) fidx = (fidx + 1) % BF;
      prior = h[63];
      sidx++;
   endtask

   // half-cell enable and line monitor
   initial begin
      forever begin
         @(negedge clk);
         if (active && !done) begin
            if (ovs_en) begin
               h[hi] = spdif_out;
               last  = spdif_out;
               hi++;
               if (hi == 64) begin
                  check_sub();
                  hi = 0;
               end
            end else begin
               tally(spdif_out == last, "R2 idle hold", {31'h0, spdif_out}, {31'h0, last});
            end
            ovs_en = ~ovs_en;
         end
      end
   end

   initial begin
      void'($urandom(32'h1D5E));
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      tally(spdif_out == 1'b0, "R1 reset level", {31'h0, spdif_out}, 32'h0);
      active = 1'b1;
      for (int n = 0; n < 80; n++) begin
         logic [1:0]  f, w;
         logic [23:0] sl, sr;
         if (n < 12) begin
            f = 2'(n % 3); w = 2'(n / 3); sl = 24'hFFFFFF; sr = 24'h000001;
         end else begin
            f = 2'($urandom % 3); w = 2'($urandom % 4);
            sl = 24'($urandom); sr = 24'($urandom);
         end
         settled = 1'b0;
         fmt = f; wsel = w;
         exp_l = placed(sl, w);
         exp_r = placed(sr, w);
         for (int fr = 0; fr < 5; fr++) begin
            if (fr == 3) settled = 1'b1;
            send_frame(sl, sr, f, w);
         end
      end
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule